// File: doc/BRIEF.md
# Capture/Compare Timer

This block is a 16-bit counter with two compare channels and one capture channel. Each system clock cycle the counter either advances or holds. It advances on a cycle when a count enable is active. That enable comes from one of three places: a prescaler tick supplied from outside, a synchronized rising edge of an external clock pin, or a synchronized falling edge of that pin. The counter can count up or down. Its top value is either all ones or the active value of compare channel A.

Each compare channel has two registers. Software writes a buffer register. The active register takes the buffer value each time the counter wraps. A match between the counter and the active register raises a flag and can toggle a waveform output. The capture channel takes its trigger from a pin or from a comparator input. The trigger passes through synchronizers, an optional run-length noise filter and an edge selector, and then copies the counter into the capture register.

Four event flags share one register, and each flag is gated by its own mask bit to drive one interrupt line. Software reaches all state through a byte-wide register bus. Writes are synchronous. Reads are combinational.

Top module: `cap_cmp_timer`

## Requirements
- R1: After reset every register reads 0, `wave_out` is 0 and `irq_out` is 0. Addresses 12 to 15 always read 0.
- R2: Register 1 bits [2:0] select the count source: 0 means none, 1 means the prescaler tick (`tick_in`), 2 means falling edges of `ext_clk_in`, 3 means rising edges of `ext_clk_in`, and 4 to 7 mean none. With no source selected the counter holds its value. With source 1 the counter advances by one on each clock edge at which `tick_in` is high.
- R3: A selected edge of `ext_clk_in` advances the counter at the third clock edge after the pin changes. The counter advances only once per pin transition, and the unselected transition has no effect.
- R4: With register 1 bit 3 at 0 the counter counts up, and on reaching TOP it moves to 0. With bit 3 at 1 it counts down, and on reaching 0 it moves to TOP. TOP is the active compare A value when register 1 bit 4 is 1, and 0xFFFF otherwise. Each wrap sets flag bit 0.
- R5: Writes to addresses 4/5 (compare A, low/high byte) and 6/7 (compare B) go to buffer registers, and reads at those addresses return the buffers. The active compare values take the buffer values only at a wrap.
- R6: On an advancing cycle in which the counter equals a channel's active value, flag bit 1 (channel A) or flag bit 2 (channel B) is set. If register 0 bit 0 (A) or bit 1 (B) is set, that channel's `wave_out` bit also toggles.
- R7: Register 0 bit 2 selects the capture source: 0 for `cap_pin_in`, 1 for `cmp_trig_in`. Register 0 bit 3 selects the capture edge: 1 for rising, 0 for falling. On the selected edge the counter value is copied into the capture register (addresses 8/9) and flag bit 3 is set. With the filter off, the copy happens at the third clock edge after the input changes.
- R8: With register 0 bit 4 set, the capture input must hold a new level for 4 consecutive synchronized samples before that level is accepted. A pulse shorter than that is ignored. An accepted rising input captures at the seventh clock edge after the change.
- R9: Writing a 1 to a bit of the flag register (address 10) clears that bit. A hardware set in the same cycle wins over the clear. `irq_out[i]` is flag bit i ANDed with bit i of the mask register (address 11).
- R10: Writes to address 2 (counter low byte) and address 3 (counter high byte) load that byte. In that cycle the write takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_in | input | 1 | Prescaler tick, one count per high cycle |
| ext_clk_in | input | 1 | External count clock pin (asynchronous) |
| cap_pin_in | input | 1 | Capture trigger pin (asynchronous) |
| cmp_trig_in | input | 1 | Comparator capture trigger (asynchronous) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| wave_out | output | 2 | Compare waveform outputs, bit 0 = A, bit 1 = B |
| irq_out | output | 4 | Masked interrupt requests, one per flag |

## Verification
A register write takes effect at the next clock edge. A count, flag or waveform change caused by `tick_in` appears at the same edge that the tick is sampled. An external clock edge moves the counter at the third edge, an unfiltered capture lands at the third edge, and a filtered capture lands at the seventh. The bench drives stimulus at falling clock edges and counts whole cycles from there. It reads the registers just after the falling edge on which a result is due. For the timing checks it also reads one cycle earlier, to confirm the result has not yet arrived. To test the set-over-clear rule, the bench places a flag-clear write exactly on the capture edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int NUM_CH    = 2;
    localparam int NUM_FLAGS = 4;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTL_A   = 4'd0;
    localparam logic [ADDR_W-1:0] A_CTL_B   = 4'd1;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'd2;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'd3;
    localparam logic [ADDR_W-1:0] A_CMP_LO  = 4'd4;  // channel i at A_CMP_LO + 2*i
    localparam logic [ADDR_W-1:0] A_CAP_LO  = 4'd8;
    localparam logic [ADDR_W-1:0] A_CAP_HI  = 4'd9;
    localparam logic [ADDR_W-1:0] A_FLAGS   = 4'd10;
    localparam logic [ADDR_W-1:0] A_MASK    = 4'd11;

    // control A fields
    localparam int CA_WAVE0   = 0;
    localparam int CA_CAP_SRC = 2;
    localparam int CA_CAP_RISE= 3;
    localparam int CA_FILT    = 4;

    // control B fields
    localparam int CB_DOWN    = 3;
    localparam int CB_TOP_CMP = 4;

    // count source codes
    localparam logic [2:0] CS_OFF      = 3'd0;
    localparam logic [2:0] CS_TICK     = 3'd1;
    localparam logic [2:0] CS_EXT_FALL = 3'd2;
    localparam logic [2:0] CS_EXT_RISE = 3'd3;

    // flag bit positions
    localparam int FL_OVF  = 0;
    localparam int FL_CMP0 = 1;
    localparam int FL_CAP  = 3;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    input  logic rise_sel,
    output logic edge_pulse
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } es_st_t;

    es_st_t st_d, st_q;
    logic   lvl;

    assign lvl = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_in};
        st_d.prev = lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign edge_pulse = rise_sel ? (lvl & ~st_q.prev) : (~lvl & st_q.prev);

    AST_ONE_STEP_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
        edge_pulse |=> (!edge_pulse || (rise_sel != $past(rise_sel)))) // R3
        else $error("external edge produced two consecutive count enables");

endmodule

// File: rtl/tmr_cap_filter.sv
module tmr_cap_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    input  logic filt_en,
    input  logic rise_sel,
    output logic cap_evt
);

    localparam int HIST_W = FILT_LEN - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [HIST_W-1:0]      hist;
        logic                   filt;
        logic                   prev;
    } cf_st_t;

    cf_st_t              st_d, st_q;
    logic                lvl;
    logic [FILT_LEN-1:0] run;
    logic                run_same;
    logic                sel_lvl;

    assign lvl      = st_q.sync[SYNC_STAGES-1];
    assign run      = {st_q.hist, lvl};
    assign run_same = (&run) | ~(|run);
    assign sel_lvl  = filt_en ? st_q.filt : lvl;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], trig_in};
        st_d.hist = {st_q.hist[HIST_W-2:0], lvl};
        st_d.filt = run_same ? lvl : st_q.filt;
        st_d.prev = sel_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cap_evt = rise_sel ? (sel_lvl & ~st_q.prev) : (~sel_lvl & st_q.prev);

    AST_FILTER_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        (st_q.filt != $past(st_q.filt)) |->
            (($past(lvl) == st_q.filt) && ($past(lvl, 2) == st_q.filt) &&
             ($past(lvl, 3) == st_q.filt))) // R8
        else $error("filtered level changed without a stable run");

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       wdata,
    input  logic             load,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wave_en,
    output logic [CNT_W-1:0] buf_val,
    output logic [CNT_W-1:0] act_val,
    output logic             match,
    output logic             wave
);

    localparam int HI_W = CNT_W - 8;

    typedef struct packed {
        logic [CNT_W-1:0] bufv;
        logic [CNT_W-1:0] act;
        logic             wave;
    } cc_st_t;

    cc_st_t st_d, st_q;

    assign match = tick && (cnt == st_q.act);

    always_comb begin
        st_d = st_q;
        if (wr_lo) st_d.bufv[7:0]       = wdata;
        if (wr_hi) st_d.bufv[CNT_W-1:8] = wdata[HI_W-1:0];
        if (load)  st_d.act             = st_q.bufv;
        if (match && wave_en) st_d.wave = ~st_q.wave;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign buf_val = st_q.bufv;
    assign act_val = st_q.act;
    assign wave    = st_q.wave;

    AST_ACTIVE_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(st_q.act)) // R5
        else $error("active compare value changed without a wrap");

    AST_WAVE_TOGGLES_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        (match && wave_en) |=> (wave != $past(wave))) // R6
        else $error("enabled match did not toggle the waveform");

endmodule

// File: rtl/cap_cmp_timer.sv
module cap_cmp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_in,
    input  logic              ext_clk_in,
    input  logic              cap_pin_in,
    input  logic              cmp_trig_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] wave_out,
    output logic [NUM_FLAGS-1:0] irq_out
);

    localparam int HI_W = CNT_W - 8;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0]     cnt;
        logic [CNT_W-1:0]     cap;
        logic [DATA_W-1:0]    ctl_a;
        logic [DATA_W-1:0]    ctl_b;
        logic [NUM_FLAGS-1:0] flags;
        logic [NUM_FLAGS-1:0] mask;
    } tm_st_t;

    tm_st_t st_d, st_q;

    logic [2:0]       csel;
    logic             ext_pulse;
    logic             tick;
    logic             down;
    logic [CNT_W-1:0] top_val;
    logic             at_end;
    logic             wrap;
    logic             cap_evt;
    logic             cap_src;
    logic             cnt_wr;
    logic [NUM_FLAGS-1:0] fl_set;
    logic [NUM_FLAGS-1:0] fl_clr;

    logic [CNT_W-1:0]  cmp_buf [NUM_CH];
    logic [CNT_W-1:0]  cmp_act [NUM_CH];
    logic [NUM_CH-1:0] cmp_match;

    // count source
    assign csel = st_q.ctl_b[2:0];

    tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ext_edge (
        .clk        (clk),
        .rst        (rst),
        .pin_in     (ext_clk_in),
        .rise_sel   (csel == CS_EXT_RISE),
        .edge_pulse (ext_pulse)
    );

    always_comb begin
        case (csel)
            CS_TICK:     tick = tick_in;
            CS_EXT_FALL: tick = ext_pulse;
            CS_EXT_RISE: tick = ext_pulse;
            default:     tick = 1'b0;
        endcase
    end

    // direction and wrap
    assign down    = st_q.ctl_b[CB_DOWN];
    assign top_val = st_q.ctl_b[CB_TOP_CMP] ? cmp_act[0] : CNT_MAX;
    assign at_end  = down ? (st_q.cnt == '0)
                          : ((st_q.cnt == top_val) || (st_q.cnt == CNT_MAX));
    assign wrap    = tick && at_end;

    // capture path
    assign cap_src = st_q.ctl_a[CA_CAP_SRC];

    tmr_cap_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .trig_in  (cap_src ? cmp_trig_in : cap_pin_in),
        .filt_en  (st_q.ctl_a[CA_FILT]),
        .rise_sel (st_q.ctl_a[CA_CAP_RISE]),
        .cap_evt  (cap_evt)
    );

    // compare channels
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        localparam logic [ADDR_W-1:0] LO_ADDR = A_CMP_LO + ADDR_W'(2 * i);
        localparam logic [ADDR_W-1:0] HI_ADDR = A_CMP_LO + ADDR_W'(2 * i + 1);

        tmr_cmp_chan #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .wr_lo   (bus_we && (bus_addr == LO_ADDR)),
            .wr_hi   (bus_we && (bus_addr == HI_ADDR)),
            .wdata   (bus_wdata),
            .load    (wrap),
            .tick    (tick),
            .cnt     (st_q.cnt),
            .wave_en (st_q.ctl_a[CA_WAVE0 + i]),
            .buf_val (cmp_buf[i]),
            .act_val (cmp_act[i]),
            .match   (cmp_match[i]),
            .wave    (wave_out[i])
        );
    end

    // flag set and clear sources
    always_comb begin
        fl_set                  = '0;
        fl_set[FL_OVF]          = wrap;
        fl_set[FL_CAP]          = cap_evt;
        for (int i = 0; i < NUM_CH; i++) fl_set[FL_CMP0 + i] = cmp_match[i];
        fl_clr = (bus_we && (bus_addr == A_FLAGS)) ? bus_wdata[NUM_FLAGS-1:0] : '0;
    end

    assign cnt_wr = bus_we && ((bus_addr == A_CNT_LO) || (bus_addr == A_CNT_HI));

    // next state
    always_comb begin
        st_d = st_q;

        if (tick) begin
            if (down) st_d.cnt = (st_q.cnt == '0) ? top_val : st_q.cnt - 1'b1;
            else      st_d.cnt = at_end ? '0 : st_q.cnt + 1'b1;
        end

        if (cap_evt) st_d.cap = st_q.cnt;

        st_d.flags = (st_q.flags & ~fl_clr) | fl_set;

        if (bus_we) begin
            case (bus_addr)
                A_CTL_A:  st_d.ctl_a           = bus_wdata;
                A_CTL_B:  st_d.ctl_b           = bus_wdata;
                A_CNT_LO: st_d.cnt[7:0]        = bus_wdata;
                A_CNT_HI: st_d.cnt[CNT_W-1:8]  = bus_wdata[HI_W-1:0];
                A_MASK:   st_d.mask            = bus_wdata[NUM_FLAGS-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTL_A:  bus_rdata = st_q.ctl_a;
            A_CTL_B:  bus_rdata = st_q.ctl_b;
            A_CNT_LO: bus_rdata = st_q.cnt[7:0];
            A_CNT_HI: bus_rdata = DATA_W'(st_q.cnt[CNT_W-1:8]);
            4'd4:     bus_rdata = cmp_buf[0][7:0];
            4'd5:     bus_rdata = DATA_W'(cmp_buf[0][CNT_W-1:8]);
            4'd6:     bus_rdata = cmp_buf[1][7:0];
            4'd7:     bus_rdata = DATA_W'(cmp_buf[1][CNT_W-1:8]);
            A_CAP_LO: bus_rdata = st_q.cap[7:0];
            A_CAP_HI: bus_rdata = DATA_W'(st_q.cap[CNT_W-1:8]);
            A_FLAGS:  bus_rdata = DATA_W'(st_q.flags);
            A_MASK:   bus_rdata = DATA_W'(st_q.mask);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_out = st_q.flags & st_q.mask;

    AST_HOLD_WITHOUT_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (((csel == CS_OFF) || (csel > CS_EXT_RISE)) && !cnt_wr) |=>
            (st_q.cnt == $past(st_q.cnt))) // R2
        else $error("counter moved with no count source");

    AST_CAPTURE_COPIES_COUNT: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> (st_q.cap == $past(st_q.cnt))) // R7
        else $error("capture register does not hold the counter value");

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cap_evt && bus_we && (bus_addr == A_FLAGS) && bus_wdata[FL_CAP]) |=>
            st_q.flags[FL_CAP]) // R9
        else $error("flag clear overrode a simultaneous set");

endmodule

// File: tb/cap_cmp_timer_tb_top.sv
module cap_cmp_timer_tb_top;
    timeunit 1ns;
    timeprecision 10ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_in = 1'b0;
    logic       ext_clk_in = 1'b0;
    logic       cap_pin_in = 1'b0;
    logic       cmp_trig_in = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] wave_out;
    logic [3:0] irq_out;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    cap_cmp_timer dut_i (
        .clk         (clk),
        .rst         (rst),
        .tick_in     (tick_in),
        .ext_clk_in  (ext_clk_in),
        .cap_pin_in  (cap_pin_in),
        .cmp_trig_in (cmp_trig_in),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wave_out    (wave_out),
        .irq_out     (irq_out)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        bus_addr = a;
        #0.1;
        v = bus_rdata;
    endtask

    task automatic rd16(input logic [3:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a + 4'd1, hi);
        v = {hi, lo};
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        @(negedge clk);
        tick_in = 1'b1;
        repeat (n) @(negedge clk);
        tick_in = 1'b0;
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(4'd2, v[7:0]);
        wr(4'd3, v[15:8]);
    endtask

    task automatic clr_flags();
        wr(4'd10, 8'h0F);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            check("R1", $sformatf("reg %0d after reset", a), 32'(v), 32'h0);
        end
        check("R1", "wave_out after reset", 32'(wave_out), 32'h0);
        check("R1", "irq_out after reset", 32'(irq_out), 32'h0);
    endtask

    task automatic t_tick_src();
        logic [15:0] c;
        wr(4'd1, 8'h01);
        tick_n(5);
        rd16(4'd2, c); check("R2", "tick source counts", 32'(c), 32'd5);
        wr(4'd1, 8'h00);
        tick_n(4);
        rd16(4'd2, c); check("R2", "no source holds", 32'(c), 32'd5);
        wr(4'd1, 8'h05);
        tick_n(3);
        rd16(4'd2, c); check("R2", "reserved source holds", 32'(c), 32'd5);
        // R10: bus write wins over a tick in the same cycle
        wr(4'd1, 8'h01);
        @(negedge clk);
        tick_in = 1'b1; bus_we = 1'b1; bus_addr = 4'd2; bus_wdata = 8'h40;
        @(negedge clk);
        tick_in = 1'b0; bus_we = 1'b0;
        rd16(4'd2, c); check("R10", "write overrides tick", 32'(c), 32'h0040);
        wr(4'd1, 8'h00);
        wr(4'd3, 8'h12);
        rd16(4'd2, c); check("R10", "high byte write", 32'(c), 32'h1240);
    endtask

    task automatic t_ext_src();
        logic [15:0] c;
        wr(4'd1, 8'h03);
        @(negedge clk); ext_clk_in = 1'b1;
        wait_n(2);
        rd16(4'd2, c); check("R3", "rise not yet counted", 32'(c), 32'h1240);
        wait_n(1);
        rd16(4'd2, c); check("R3", "rise counted at third edge", 32'(c), 32'h1241);
        wait_n(3);
        rd16(4'd2, c); check("R3", "single step per rise", 32'(c), 32'h1241);
        @(negedge clk); ext_clk_in = 1'b0;
        wait_n(5);
        rd16(4'd2, c); check("R3", "fall ignored in rise mode", 32'(c), 32'h1241);
        wr(4'd1, 8'h02);
        @(negedge clk); ext_clk_in = 1'b1;
        wait_n(5);
        rd16(4'd2, c); check("R3", "rise ignored in fall mode", 32'(c), 32'h1241);
        @(negedge clk); ext_clk_in = 1'b0;
        wait_n(2);
        rd16(4'd2, c); check("R3", "fall not yet counted", 32'(c), 32'h1241);
        wait_n(1);
        rd16(4'd2, c); check("R3", "fall counted", 32'(c), 32'h1242);
        wr(4'd1, 8'h00);
    endtask

    task automatic t_wrap_buf();
        logic [15:0] c;
        logic [7:0]  f;
        clr_flags();
        set_cnt(16'h0000);
        wr(4'd4, 8'h05); wr(4'd5, 8'h00);
        rd16(4'd4, c); check("R5", "compare A buffer readback", 32'(c), 32'd5);
        wr(4'd1, 8'h11);
        tick_n(1);
        rd16(4'd2, c); check("R4", "wrap at top of zero", 32'(c), 32'd0);
        rd(4'd10, f);  check("R4", "flags at first wrap", 32'(f), 32'h07);
        clr_flags();
        tick_n(5);
        rd16(4'd2, c); check("R4", "count up to 5", 32'(c), 32'd5);
        rd(4'd10, f);  check("R6", "only B matched on the way", 32'(f), 32'h04);
        clr_flags();
        tick_n(1);
        rd16(4'd2, c); check("R4", "wrap at compare A top", 32'(c), 32'd0);
        rd(4'd10, f);  check("R6", "overflow and A match", 32'(f), 32'h03);
        wr(4'd4, 8'h03);
        rd16(4'd4, c); check("R5", "buffer reads new value", 32'(c), 32'd3);
        clr_flags();
        tick_n(4);
        rd16(4'd2, c); check("R5", "old top still active", 32'(c), 32'd4);
        rd(4'd10, f);  check("R5", "no wrap at buffered value", 32'(f), 32'h04);
        tick_n(2);
        tick_n(3);
        rd16(4'd2, c); check("R5", "new top loaded at wrap", 32'(c), 32'd3);
        tick_n(1);
        rd16(4'd2, c); check("R5", "wrap at new top", 32'(c), 32'd0);
        clr_flags();
        wr(4'd1, 8'h19);
        tick_n(1);
        rd16(4'd2, c); check("R4", "down wrap to top", 32'(c), 32'd3);
        rd(4'd10, f);  check("R4", "down wrap flags", 32'(f), 32'h05);
        tick_n(1);
        rd16(4'd2, c); check("R4", "down count", 32'(c), 32'd2);
        wr(4'd1, 8'h01);
        set_cnt(16'hFFFE);
        clr_flags();
        tick_n(2);
        rd16(4'd2, c); check("R4", "full range wrap", 32'(c), 32'd0);
        rd(4'd10, f);  check("R4", "full range overflow flag", 32'(f), 32'h01);
        wr(4'd1, 8'h00);
    endtask

    task automatic t_wave();
        set_cnt(16'h0000);
        wr(4'd0, 8'h01);
        wr(4'd1, 8'h11);
        tick_n(4);
        check("R6", "A toggles, B disabled", 32'(wave_out), 32'h1);
        tick_n(4);
        check("R6", "A toggles back", 32'(wave_out), 32'h0);
        wr(4'd1, 8'h00);
        wr(4'd0, 8'h00);
    endtask

    task automatic t_capture();
        logic [15:0] c;
        logic [7:0]  f;
        set_cnt(16'h1234);
        clr_flags();
        wr(4'd0, 8'h08);
        @(negedge clk); cap_pin_in = 1'b1;
        wait_n(2);
        rd(4'd10, f);  check("R7", "capture not yet", 32'(f), 32'h00);
        wait_n(1);
        rd(4'd10, f);  check("R7", "capture flag at third edge", 32'(f), 32'h08);
        rd16(4'd8, c); check("R7", "captured count", 32'(c), 32'h1234);
        @(negedge clk); cmp_trig_in = 1'b1;
        wait_n(4);
        clr_flags();
        wr(4'd2, 8'h56);
        wr(4'd0, 8'h0C);
        @(negedge clk); cap_pin_in = 1'b0;
        wait_n(5);
        rd(4'd10, f);  check("R7", "pin ignored with comparator source", 32'(f), 32'h00);
        @(negedge clk); cmp_trig_in = 1'b0;
        wait_n(5);
        rd(4'd10, f);  check("R7", "falling ignored in rising mode", 32'(f), 32'h00);
        @(negedge clk); cmp_trig_in = 1'b1;
        wait_n(3);
        rd(4'd10, f);  check("R7", "comparator rising capture", 32'(f), 32'h08);
        rd16(4'd8, c); check("R7", "comparator captured count", 32'(c), 32'h1256);
        clr_flags();
        wr(4'd2, 8'h78);
        wr(4'd0, 8'h04);
        @(negedge clk); cmp_trig_in = 1'b0;
        wait_n(3);
        rd(4'd10, f);  check("R7", "falling edge capture", 32'(f), 32'h08);
        rd16(4'd8, c); check("R7", "falling captured count", 32'(c), 32'h1278);
    endtask

    task automatic t_filter();
        logic [15:0] c;
        logic [7:0]  f;
        clr_flags();
        wr(4'd0, 8'h18);
        wait_n(6);
        set_cnt(16'h0101);
        @(negedge clk); cap_pin_in = 1'b1;
        wait_n(3);
        cap_pin_in = 1'b0;
        wait_n(10);
        rd(4'd10, f);  check("R8", "short pulse rejected", 32'(f), 32'h00);
        @(negedge clk); cap_pin_in = 1'b1;
        wait_n(6);
        rd(4'd10, f);  check("R8", "filtered capture not yet", 32'(f), 32'h00);
        wait_n(1);
        rd(4'd10, f);  check("R8", "filtered capture at seventh edge", 32'(f), 32'h08);
        rd16(4'd8, c); check("R8", "filtered captured count", 32'(c), 32'h0101);
    endtask

    task automatic t_flags();
        logic [7:0] f;
        wr(4'd11, 8'h08);
        check("R9", "masked flag raises irq", 32'(irq_out), 32'h8);
        wr(4'd11, 8'h00);
        check("R9", "mask off drops irq", 32'(irq_out), 32'h0);
        wr(4'd10, 8'h08);
        rd(4'd10, f);  check("R9", "write one clears", 32'(f), 32'h00);
        wr(4'd0, 8'h08);
        @(negedge clk); cap_pin_in = 1'b0;
        wait_n(4);
        @(negedge clk); cap_pin_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'd10; bus_wdata = 8'h08;
        @(negedge clk);
        bus_we = 1'b0;
        rd(4'd10, f);  check("R9", "set wins over clear", 32'(f), 32'h08);
        wr(4'd10, 8'h08);
        rd(4'd10, f);  check("R9", "later clear works", 32'(f), 32'h00);
    endtask

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(1);
        t_reset();
        t_tick_src();
        t_ext_src();
        t_wrap_buf();
        t_wave();
        t_capture();
        t_filter();
        t_flags();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #250000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule